// File: doc/BRIEF.md
# Trapping Set Neutralization Propagation Engine

An iterative decoder for sparse parity-check codes can lock into a stable wrong state in which a small group of bit nodes reinforce each other's errors. When that happens, a few parity checks stay unsatisfied and their pattern stops changing. This engine works on a small fixed bipartite graph of `NV` bit nodes and `NC` check nodes, where every check node has `DC` links. When the decoder detects such a lock, it starts the engine with the vector of unsatisfied checks. The engine then spreads clearing tokens from those checks into the bit nodes of the offending group. It reports a mask of the bit nodes whose channel value and outgoing edge messages the decoder must force to zero before it resumes its iterations.

The path of the tokens is set by configuration bits that are prepared offline:
- One relay-enable bit for each bit node.
- One launch bit for each check link.
- One routing word of `DC` bits for each check link, which selects the incoming links that feed it.

The graph is fixed. Link `q` of check `j` reaches bit node `(j + q*STRIDE) mod NV`. `STRIDE` must give `DC` distinct bit nodes per check. Tokens make one hop per clock. The hops alternate between check-to-bit and bit-to-check, and they continue for the programmed number of hops.

Top module: `tsn_engine`

## Requirements
- R1: After reset, `neutralize` is all zero and `done` is 0.
- R2: On the `start` edge, check `j` launches a token on link `q` only when `unsat[j]` and `link_init_en[j*DC+q]` are both 1. Link `q` of check `j` leads to bit node `(j+q*STRIDE) mod NV`. A zero `unsat` or a zero launch vector launches nothing.
- R3: Any bit node that receives a token gets its bit set in `neutralize`. The mask bits stay set until the next `start`, which clears the whole mask.
- R4: A bit node `v` that receives a token forwards it only when `var_fwd_en[v]` is 1. It forwards on every one of its links except the link the token came from.
- R5: A check `j` that receives a token on link `p` sends it out on every link `q` where bit `p` of `link_fwd_map[(j*DC+q)*DC +: DC]` is 1.
- R6: Hop `k` (counting from 1) falls on the `k`-th clock edge after the `start` edge. Odd hops deliver check-to-bit and update the mask. Even hops deliver bit-to-check. `done` rises on the edge that executes hop `nt_cycles`. From then on the mask stays frozen and `done` stays high until the next `start`.
- R7: When `nt_cycles` is 0, `done` is 1 and the mask is zero right after the `start` edge.
- R8: When all configuration is zero, nothing is launched and nothing is forwarded, so the mask stays zero for any `unsat`.
- R9: A `start` that arrives while the engine is busy abandons the current run. It clears the mask and begins a new run with the new inputs.
- R10: Tokens that reach the same node in the same hop are OR-combined. A bit node reached from two checks is marked once. It then relays to each of those checks the token that came from the other one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle pulse that captures the inputs and starts a run |
| unsat | input | NC | Unsatisfied-check vector, one bit per check |
| var_fwd_en | input | NV | Relay enable, one bit per bit node |
| link_init_en | input | NC*DC | Launch bit per check link, at index j*DC+q |
| link_fwd_map | input | NC*DC*DC | Routing word per check link, bit p at (j*DC+q)*DC+p |
| nt_cycles | input | CNT_W | Number of hops to run |
| neutralize | output | NV | Sticky mask of bit nodes to clear |
| done | output | 1 | High once the programmed hops are finished |

## Verification
The `start` edge clears the mask. When `nt_cycles` is nonzero, the mask reads zero one cycle later. The final mask and the rising `done` appear `nt_cycles` clock edges after the `start` edge. With `nt_cycles` of 0, both appear right after the `start` edge.

The scoreboard sets a latency counter to zero on the first falling edge after the `start` edge. It counts one per falling edge until `done` is seen. It then checks the latency against `nt_cycles` and the mask against its own hop-by-hop model of the routing rules. It also checks that the mask reads zero on that first falling edge.

Stickiness is checked over several idle cycles after a run finishes. An abandoned run is checked by restarting the engine while it is busy and comparing the result only against the second run.

// File: rtl/tsn_pkg.sv
package tsn_pkg;
  // Flat link index l = j*dc + q; returns the bit node that link reaches.
  function automatic int link_var(input int l, input int dc, input int nv, input int stride);
    return ((l / dc) + (l % dc) * stride) % nv;
  endfunction
endpackage

// File: rtl/tsn_ctrl.sv
module tsn_ctrl #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CNT_W-1:0] nt_cycles,
  output logic             busy,
  output logic             done,
  output logic             hop_deliver,
  output logic             hop_forward
);
  logic [CNT_W-1:0] cnt_q, nt_q, hop;

  assign hop         = cnt_q + {{(CNT_W-1){1'b0}}, 1'b1};
  assign hop_deliver = busy & hop[0];
  assign hop_forward = busy & ~hop[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      nt_q  <= '0;
      busy  <= 1'b0;
      done  <= 1'b0;
    end else if (start) begin
      cnt_q <= '0;
      nt_q  <= nt_cycles;
      busy  <= (nt_cycles != '0);
      done  <= (nt_cycles == '0);
    end else if (busy) begin
      cnt_q <= hop;
      if (hop == nt_q) begin
        busy <= 1'b0;
        done <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/tsn_check_node.sv
module tsn_check_node #(
  parameter int DC = 4
) (
  input  logic             unsat_bit,
  input  logic [DC-1:0]    launch_en,
  input  logic [DC*DC-1:0] route_map,
  input  logic [DC-1:0]    tok_in,
  output logic [DC-1:0]    tok_launch,
  output logic [DC-1:0]    tok_route
);
  for (genvar q = 0; q < DC; q++) begin : g_link
    assign tok_launch[q] = unsat_bit & launch_en[q];
    assign tok_route[q]  = |(route_map[q*DC +: DC] & tok_in);
  end
endmodule

// File: rtl/tsn_var_route.sv
module tsn_var_route
  import tsn_pkg::*;
#(
  parameter int NV     = 12,
  parameter int NC     = 6,
  parameter int DC     = 4,
  parameter int STRIDE = 3,
  localparam int L     = NC * DC
) (
  input  logic [L-1:0]  c2v,
  input  logic [NV-1:0] relay_en,
  output logic [NV-1:0] recv,
  output logic [L-1:0]  v2c
);
  always_comb begin
    logic any_other;
    recv = '0;
    v2c  = '0;
    for (int l = 0; l < L; l++) begin
      recv[link_var(l, DC, NV, STRIDE)] |= c2v[l];
    end
    for (int l = 0; l < L; l++) begin
      any_other = 1'b0;
      for (int k = 0; k < L; k++) begin
        if (k != l && link_var(k, DC, NV, STRIDE) == link_var(l, DC, NV, STRIDE))
          any_other |= c2v[k];
      end
      v2c[l] = relay_en[link_var(l, DC, NV, STRIDE)] & any_other;
    end
  end
endmodule

// File: rtl/tsn_engine.sv
module tsn_engine #(
  parameter int NV     = 12,
  parameter int NC     = 6,
  parameter int DC     = 4,
  parameter int STRIDE = 3,
  parameter int CNT_W  = 4,
  localparam int L     = NC * DC
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [NC-1:0]    unsat,
  input  logic [NV-1:0]    var_fwd_en,
  input  logic [L-1:0]     link_init_en,
  input  logic [L*DC-1:0]  link_fwd_map,
  input  logic [CNT_W-1:0] nt_cycles,
  output logic [NV-1:0]    neutralize,
  output logic             done
);
  logic             busy, hop_deliver, hop_forward;
  logic [NV-1:0]    relay_q, recv;
  logic [L*DC-1:0]  route_q;
  logic [L-1:0]     c2v_q, v2c_q, launch_tok, route_tok, v2c_next;

  tsn_ctrl #(.CNT_W(CNT_W)) i_ctrl (
    .clk, .rst_n, .start, .nt_cycles,
    .busy, .done, .hop_deliver, .hop_forward
  );

  for (genvar j = 0; j < NC; j++) begin : g_chk
    tsn_check_node #(.DC(DC)) i_node (
      .unsat_bit  (unsat[j]),
      .launch_en  (link_init_en[j*DC +: DC]),
      .route_map  (route_q[j*DC*DC +: DC*DC]),
      .tok_in     (v2c_q[j*DC +: DC]),
      .tok_launch (launch_tok[j*DC +: DC]),
      .tok_route  (route_tok[j*DC +: DC])
    );
  end

  tsn_var_route #(.NV(NV), .NC(NC), .DC(DC), .STRIDE(STRIDE)) i_route (
    .c2v (c2v_q), .relay_en (relay_q), .recv (recv), .v2c (v2c_next)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      relay_q    <= '0;
      route_q    <= '0;
      c2v_q      <= '0;
      v2c_q      <= '0;
      neutralize <= '0;
    end else if (start) begin
      relay_q    <= var_fwd_en;
      route_q    <= link_fwd_map;
      c2v_q      <= launch_tok;
      v2c_q      <= '0;
      neutralize <= '0;
    end else if (hop_deliver) begin
      neutralize <= neutralize | recv;
      v2c_q      <= v2c_next;
    end else if (hop_forward) begin
      c2v_q      <= route_tok;
    end
  end
endmodule

// File: rtl/tsn_engine_chk.sv
module tsn_engine_chk #(
  parameter int NV     = 12,
  parameter int NC     = 6,
  parameter int DC     = 4,
  parameter int CNT_W  = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic [NC-1:0]    unsat,
  input logic [NC*DC-1:0] link_init_en,
  input logic [CNT_W-1:0] nt_cycles,
  input logic [NV-1:0]    neutralize,
  input logic             done,
  input logic             busy,
  input logic             hop_deliver,
  input logic [NC*DC-1:0] c2v_q
);
  AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (start && nt_cycles != '0) |=> (neutralize == '0 && !done)); // R3
  AST_ZERO_HOPS: assert property (@(posedge clk) disable iff (!rst_n)
    (start && nt_cycles == '0) |=> (done && neutralize == '0)); // R7
  AST_MASK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> ((neutralize & $past(neutralize)) == $past(neutralize))); // R3
  AST_MASK_ON_DELIVER: assert property (@(posedge clk) disable iff (!rst_n)
    (!start && !hop_deliver) |=> $stable(neutralize)); // R6
  AST_DONE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> (done && $stable(neutralize))); // R6
  AST_BUSY_DONE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && done)); // R6
  AST_NO_LAUNCH: assert property (@(posedge clk) disable iff (!rst_n)
    (start && (unsat == '0 || link_init_en == '0)) |=> (c2v_q == '0)); // R2
endmodule

bind tsn_engine tsn_engine_chk #(.NV(NV), .NC(NC), .DC(DC), .CNT_W(CNT_W)) i_chk (.*);

// File: tb/test_tsn_engine.sv
`timescale 1ns/1ps
module test_tsn_engine;
  localparam int NV = 12, NC = 6, DC = 4, STRIDE = 3, CNT_W = 4;
  localparam int L = NC * DC;

  typedef struct { logic [NV-1:0] mask; int nt; } exp_t;

  logic clk = 0, rst_n = 0, start = 0;
  logic [NC-1:0]    g_unsat = '0;
  logic [NV-1:0]    g_gamma = '0;
  logic [L-1:0]     g_beta  = '0;
  logic [L*DC-1:0]  g_alpha = '0;
  logic [CNT_W-1:0] nt = '0;
  logic [NV-1:0]    neutralize;
  logic             done;
  int checks = 0, errors = 0, lat = 0;
  exp_t sb[$];

  always #2.5 clk = ~clk;

  tsn_engine #(.NV(NV), .NC(NC), .DC(DC), .STRIDE(STRIDE), .CNT_W(CNT_W)) i_tsn_engine (
    .clk, .rst_n, .start, .unsat(g_unsat), .var_fwd_en(g_gamma),
    .link_init_en(g_beta), .link_fwd_map(g_alpha), .nt_cycles(nt),
    .neutralize, .done
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Reference: hop-by-hop token model built from the requirement text.
  function automatic logic [NV-1:0] model(input int hops);
    bit c2v[NC][DC], v2c[NC][DC];
    int vid[NC][DC];
    logic [NV-1:0] m = '0;
    for (int j = 0; j < NC; j++)
      for (int q = 0; q < DC; q++) begin
        int v = j;
        for (int k = 0; k < q; k++) v = (v + STRIDE) % NV;
        vid[j][q] = v;
        c2v[j][q] = g_unsat[j] & g_beta[j*DC+q];
        v2c[j][q] = 0;
      end
    for (int h = 1; h <= hops; h++) begin
      if (h % 2 == 1) begin
        for (int j = 0; j < NC; j++)
          for (int q = 0; q < DC; q++) if (c2v[j][q]) m[vid[j][q]] = 1'b1;
        for (int j = 0; j < NC; j++)
          for (int q = 0; q < DC; q++) begin
            bit any = 0;
            for (int j2 = 0; j2 < NC; j2++)
              for (int q2 = 0; q2 < DC; q2++)
                if (!(j2 == j && q2 == q) && vid[j2][q2] == vid[j][q] && c2v[j2][q2]) any = 1;
            v2c[j][q] = g_gamma[vid[j][q]] & any;
          end
      end else begin
        for (int j = 0; j < NC; j++)
          for (int q = 0; q < DC; q++) begin
            bit o = 0;
            for (int p = 0; p < DC; p++) o |= g_alpha[(j*DC+q)*DC+p] & v2c[j][p];
            c2v[j][q] = o;
          end
      end
    end
    return m;
  endfunction

  task automatic run(input int hops);
    exp_t e;
    @(negedge clk);
    nt = CNT_W'(hops);
    start = 1;
    @(posedge clk);
    #1;
    start = 0;
    e.mask = model(hops);
    e.nt = hops;
    sb.push_back(e);
    while (sb.size() != 0) @(negedge clk);
  endtask

  // Monitor: lat is 0 on the first falling edge after the start edge.
  always @(negedge clk) begin
    if (rst_n && sb.size() > 0) begin
      if (lat == 0 && !done) check(neutralize == '0, "R3 clear on start", 32'(neutralize), 0);
      if (done) begin
        check(neutralize == sb[0].mask, (sb[0].nt == 0) ? "R7 mask" : "R2/R4/R5/R10 mask",
              32'(neutralize), 32'(sb[0].mask));
        check(lat == sb[0].nt, (sb[0].nt == 0) ? "R7 latency" : "R6 latency", lat, sb[0].nt);
        void'(sb.pop_front());
        lat = 0;
      end else lat++;
    end
  end

  task automatic clear_cfg();
    g_unsat = '0; g_gamma = '0; g_beta = '0; g_alpha = '0;
  endtask

  initial begin
    fork
      begin
        #1000000;
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    join_none
    repeat (3) @(negedge clk);
    check(neutralize == '0 && done == 0, "R1 reset", {neutralize, done}, 0);
    rst_n = 1;
    repeat (2) @(negedge clk);
    check(neutralize == '0 && done == 0, "R1 idle after reset", {neutralize, done}, 0);

    // R8: zero configuration, unsatisfied checks present.
    clear_cfg(); g_unsat = '1; run(5);
    // R2: launch bits set, but no unsatisfied check.
    clear_cfg(); g_beta = '1; run(3);
    // R2: check0 link1 -> bit node 3, one hop.
    clear_cfg(); g_unsat[0] = 1; g_beta[0*DC+1] = 1; run(1);
    // R4/R5: relay via node3 into check3 link0, routed to link2 (node 9);
    // check0 routes link1->link2 but node3 must not echo back to check0.
    g_gamma[3] = 1; g_alpha[(3*DC+2)*DC+0] = 1; g_alpha[(0*DC+2)*DC+1] = 1;
    run(2); run(3); run(6);
    // R3: sticky mask and held done while idle.
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      check(neutralize == 12'h208 && done, "R3 sticky", 32'(neutralize), 32'h208);
    end
    // R4: relay disabled.
    g_gamma[3] = 0; run(3);
    // R7: zero hops.
    run(0);
    // R10: node0 reached from check0 link0 and check3 link3 in the same hop.
    clear_cfg(); g_unsat[0] = 1; g_unsat[3] = 1;
    g_beta[0*DC+0] = 1; g_beta[3*DC+3] = 1; g_gamma[0] = 1;
    g_alpha[(3*DC+1)*DC+3] = 1; g_alpha[(0*DC+2)*DC+0] = 1;
    run(3); run(5);
    // R9: restart while busy; the first run marks node1, the second must not.
    clear_cfg(); g_unsat[1] = 1; g_beta[1*DC+0] = 1;
    @(negedge clk); nt = 4'd9; start = 1;
    @(negedge clk); start = 0;
    repeat (2) @(negedge clk);
    check(neutralize[1] == 1'b1 && !done, "R9 first run active", 32'(neutralize), 2);
    clear_cfg(); g_unsat[0] = 1; g_beta[0*DC+1] = 1;
    run(1);
    check(neutralize == 12'h008, "R9 restart result", 32'(neutralize), 8);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule